// File: doc/BRIEF.md
# Decoder Play/Mute Gate Controller

This block sits between an audio decoder core and the serialiser that carries its PCM samples off chip. It works in two phases. After reset it is in a start-up phase. In that phase it keeps the core clock enabled, keeps decoding disabled and forces the PCM output to zero. It also ignores the play and mute requests. The start-up phase ends when the core reports that its first decoded samples have reached the output stage. At that moment the block captures the requests, moves to the decode phase and stays there until the next reset.

In the decode phase the two requests select one of four settings. Each setting fixes whether the core clock runs, whether decoding is enabled and whether samples reach the output. The play and mute requests arrive from another clock domain, so each passes through a flop synchroniser first. A new setting is applied only on a sample boundary. A sample is therefore never cut partway through. The output valid strobe keeps its timing even while the output is zeroed, so the serialiser still receives a steady stream of zero samples.

Top module: `pcm_play_gate`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, the outputs are: dec_en=0, core_ce=1, pcm_data=0, pcm_vld=0. The block is then in the start-up phase.
- R2: In the start-up phase, changes on play_req and mute_req have no effect. dec_en stays 0, core_ce stays 1, and pcm_data is 0 on every cycle.
- R3: When first_out is 1 at a clock edge during start-up, the decode phase begins at that edge. The synchronised play/mute values are captured at the same edge. The block stays in the decode phase until reset.
- R4: In the decode phase with play=0 and mute=0: core_ce=0, dec_en=0 and pcm_data=0.
- R5: In the decode phase with play=0 and mute=1: core_ce=1, dec_en=0 and pcm_data=0.
- R6: In the decode phase with play=1 and mute=0: core_ce=1 and dec_en=1. When smp_vld=1 at an edge, pcm_data equals smp_data after that edge.
- R7: In the decode phase with play=1 and mute=1: core_ce=1, dec_en=1 and pcm_data=0.
- R8: pcm_vld equals smp_vld delayed by one clock, whatever the gating. pcm_data is 0 on every cycle where pcm_vld is 0.
- R9: Each request passes through SYNC_STAGES flops before it is used. In the decode phase, the captured setting changes only at an edge where smp_vld=1, or at an edge where core_ce=0 (the core is stopped, so no sample is in flight).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| play_req | input | 1 | Play request, asynchronous |
| mute_req | input | 1 | Mute request, asynchronous |
| first_out | input | 1 | Core reports that its first decoded samples are at the output stage |
| smp_data | input | SAMPLE_W | Decoded sample from the core |
| smp_vld | input | 1 | smp_data is valid this cycle |
| dec_en | output | 1 | Decoding enable to the core |
| core_ce | output | 1 | Core clock enable; 0 stands for a stopped clock |
| pcm_data | output | SAMPLE_W | Gated PCM sample to the serialiser |
| pcm_vld | output | 1 | pcm_data strobe |

## Verification
The requests are toggled during start-up while samples stream in. This shows that the start-up phase neither reacts to the requests nor leaks samples. In the decode phase the bench steps through all four play/mute settings, with gaps in the valid pattern. This separates the settings from one another: only the pass-through setting reproduces the input samples, and only the stopped setting drops core_ce. A request is also changed during a gap between samples, and the bench checks that the setting stays put until the next sample. The block is then reset and entered with a different captured setting, which exercises the capture at the phase change.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

   typedef enum logic {
      PH_START = 1'b0,
      PH_RUN   = 1'b1
   } phase_e;

   typedef struct packed {
      logic play;
      logic mute;
   } knob_t;

   typedef struct packed {
      logic dec_en;
      logic core_ce;
      logic pass;
   } gate_t;

   // Control outputs for a phase and a captured knob setting
   function automatic gate_t gate_table(input phase_e ph, input knob_t k);
      gate_t g;
      if (ph == PH_START) begin
         g.dec_en  = 1'b0;
         g.core_ce = 1'b1;
         g.pass    = 1'b0;
      end else begin
         unique case ({k.play, k.mute})
            2'b00:   begin g.dec_en = 1'b0; g.core_ce = 1'b0; g.pass = 1'b0; end
            2'b01:   begin g.dec_en = 1'b0; g.core_ce = 1'b1; g.pass = 1'b0; end
            2'b10:   begin g.dec_en = 1'b1; g.core_ce = 1'b1; g.pass = 1'b1; end
            default: begin g.dec_en = 1'b1; g.core_ce = 1'b1; g.pass = 1'b0; end
         endcase
      end
      return g;
   endfunction

endpackage

// File: rtl/pgate_sync.sv
module pgate_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pgate_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pgate_sync: W must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[LAST];

endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
   import pgate_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   first_out,
   input  logic   smp_vld,
   input  knob_t  knob_sync,
   output phase_e phase,
   output knob_t  knob,
   output gate_t  gate
);
   logic boundary;

   assign gate     = gate_table(phase, knob);
   // A setting may change with a sample, or while the core is stopped
   assign boundary = (phase == PH_RUN) && (smp_vld || !gate.core_ce);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_START;
         knob  <= '0;
      end else if (phase == PH_START) begin
         if (first_out) begin
            phase <= PH_RUN;
            knob  <= knob_sync;
         end
      end else if (boundary) begin
         knob <= knob_sync;
      end
   end

   AST_START_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_START && !first_out) |=> (phase == PH_START && $stable(knob))); // R2

   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN) |=> (phase == PH_RUN)); // R3

   AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_START && first_out) |=> (phase == PH_RUN && knob == $past(knob_sync))); // R3

   AST_HOLD_MID_SAMPLE: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN && !smp_vld && gate.core_ce) |=> $stable(knob)); // R9

endmodule

// File: rtl/pgate_out.sv
module pgate_out #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pass,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_vld,
   output logic [SAMPLE_W-1:0] pcm_data,
   output logic                pcm_vld
);
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("pgate_out: SAMPLE_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pcm_data <= '0;
         pcm_vld  <= 1'b0;
      end else begin
         pcm_vld  <= smp_vld;
         pcm_data <= (smp_vld && pass) ? smp_data : '0;
      end
   end

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      smp_vld |=> pcm_vld); // R8

   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> (!pcm_vld && pcm_data == '0)); // R8

   AST_ZERO_WHEN_GATED: assert property (@(posedge clk) disable iff (rst)
      !pass |=> (pcm_data == '0)); // R5

endmodule

// File: rtl/pcm_play_gate.sv
module pcm_play_gate
   import pgate_pkg::*;
#(
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                play_req,
   input  logic                mute_req,
   input  logic                first_out,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_vld,
   output logic                dec_en,
   output logic                core_ce,
   output logic [SAMPLE_W-1:0] pcm_data,
   output logic                pcm_vld
);
   localparam int KNOB_W = $bits(knob_t);

   logic [KNOB_W-1:0] req_raw;
   logic [KNOB_W-1:0] req_sync;
   knob_t             knob_sync;
   knob_t             knob;
   phase_e            phase;
   gate_t             gate;

   assign req_raw   = {play_req, mute_req};
   assign knob_sync = knob_t'(req_sync);

   pgate_sync #(.STAGES(SYNC_STAGES), .W(KNOB_W)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (req_raw),
      .q   (req_sync)
   );

   pgate_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .first_out (first_out),
      .smp_vld   (smp_vld),
      .knob_sync (knob_sync),
      .phase     (phase),
      .knob      (knob),
      .gate      (gate)
   );

   pgate_out #(.SAMPLE_W(SAMPLE_W)) u_out (
      .clk      (clk),
      .rst      (rst),
      .pass     (gate.pass),
      .smp_data (smp_data),
      .smp_vld  (smp_vld),
      .pcm_data (pcm_data),
      .pcm_vld  (pcm_vld)
   );

   assign dec_en  = gate.dec_en;
   assign core_ce = gate.core_ce;

   AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
      !core_ce |=> (pcm_data == '0)); // R4

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN && knob.play && !knob.mute && smp_vld) |=> (pcm_data == $past(smp_data))); // R6

   AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_RUN && knob.play && knob.mute) |=> (pcm_data == '0)); // R7

   AST_START_SILENT: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_START) |-> (core_ce && !dec_en)); // R2

endmodule

// File: tb/sim_pcm_play_gate.sv
`timescale 1ns/1ps
module sim_pcm_play_gate;
   localparam int SW = 16;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic play_req = 1'b0, mute_req = 1'b0, first_out = 1'b0, smp_vld = 1'b0;
   logic [SW-1:0] smp_data = '0;
   logic dec_en, core_ce, pcm_vld;
   logic [SW-1:0] pcm_data;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   pcm_play_gate #(.SAMPLE_W(SW), .SYNC_STAGES(NS)) u0 (
      .clk(clk), .rst(rst), .play_req(play_req), .mute_req(mute_req),
      .first_out(first_out), .smp_data(smp_data), .smp_vld(smp_vld),
      .dec_en(dec_en), .core_ce(core_ce), .pcm_data(pcm_data), .pcm_vld(pcm_vld));

   // Behavioural reference model
   bit m_run, m_play, m_mute, m_vld;
   logic [SW-1:0] m_data;
   bit qp[$], qm[$];

   function automatic bit m_ce();   return !m_run || m_play || m_mute; endfunction
   function automatic bit m_dec();  return m_run && m_play;            endfunction
   function automatic bit m_pass(); return m_run && m_play && !m_mute; endfunction
   function automatic string m_tag();
      if (!m_run) return "R2";
      case ({m_play, m_mute})
         2'b00:   return "R4";
         2'b01:   return "R5";
         2'b10:   return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      for (int i = 0; i < NS; i++) begin qp.push_back(1'b0); qm.push_back(1'b0); end
   end

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_run = 0; m_play = 0; m_mute = 0; m_vld = 0; m_data = '0;
         for (int i = 0; i < NS; i++) begin qp[i] = 1'b0; qm[i] = 1'b0; end
      end else begin
         bit sp, sm, ce;
         sp = qp[NS-1]; sm = qm[NS-1]; ce = m_ce();
         m_data = (smp_vld && m_pass()) ? smp_data : '0;
         m_vld  = smp_vld;
         if (!m_run) begin
            if (first_out) begin m_run = 1; m_play = sp; m_mute = sm; end
         end else if (smp_vld || !ce) begin
            m_play = sp; m_mute = sm;
         end
         qp.push_front(play_req); void'(qp.pop_back());
         qm.push_front(mute_req); void'(qm.pop_back());
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // Compare against the model every cycle, away from the edge
   always @(negedge clk) begin
      if (!rst) begin
         chk(m_tag(), "dec_en",   32'(dec_en),   32'(m_dec()));
         chk(m_tag(), "core_ce",  32'(core_ce),  32'(m_ce()));
         chk(m_tag(), "pcm_data", 32'(pcm_data), 32'(m_data));
         chk("R8",    "pcm_vld",  32'(pcm_vld),  32'(m_vld));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   int sctr = 1;
   task automatic stream(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld  = (i % 3) != 2;
         smp_data = SW'(16'h1200 + sctr * 7);
         sctr++;
      end
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      step(3);
      // R1: outputs during reset
      chk("R1", "dec_en in reset",   32'(dec_en),   32'd0);
      chk("R1", "core_ce in reset",  32'(core_ce),  32'd1);
      chk("R1", "pcm_data in reset", 32'(pcm_data), 32'd0);
      chk("R1", "pcm_vld in reset",  32'(pcm_vld),  32'd0);
      rst = 1'b0;
      step(1);
      chk("R1", "dec_en after reset", 32'(dec_en), 32'd0);

      // R2: requests toggled during start-up while samples stream
      play_req = 1'b1; stream(4);
      mute_req = 1'b1; stream(4);
      play_req = 1'b0; stream(3);
      chk("R2", "dec_en in start-up",  32'(dec_en),  32'd0);
      chk("R2", "core_ce in start-up", 32'(core_ce), 32'd1);

      // R3: enter decode with play=1, mute=0 captured
      play_req = 1'b1; mute_req = 1'b0; step(NS + 1);
      first_out = 1'b1; step(1); first_out = 1'b0;
      chk("R3", "dec_en after entry", 32'(dec_en), 32'd1);

      // R6: pass-through
      stream(9);
      // R9: change request during a gap; setting holds until a sample
      play_req = 1'b1; mute_req = 1'b1; step(NS + 3);
      chk("R9", "pass setting held without sample", 32'({dec_en, core_ce}), 32'b11);
      stream(6);   // R7
      play_req = 1'b0; stream(6);   // R5
      chk("R5", "dec_en muted idle", 32'(dec_en), 32'd0);
      mute_req = 1'b0; stream(4);   // R4 with a core that is then stopped
      step(NS + 2);
      chk("R4", "core_ce stopped", 32'(core_ce), 32'd0);
      smp_vld = 1'b1; smp_data = 16'hBEEF; step(1); smp_vld = 1'b0; step(1);
      play_req = 1'b1; step(NS + 3);
      chk("R9", "restart from stopped without sample", 32'(dec_en), 32'd1);
      stream(8);

      // R3: reset, capture a mute-only setting at entry
      rst = 1'b1; step(2); rst = 1'b0;
      play_req = 1'b0; mute_req = 1'b1; step(NS + 2);
      stream(3);
      first_out = 1'b1; step(1); first_out = 1'b0;
      chk("R3", "core_ce after mute entry", 32'(core_ce), 32'd1);
      chk("R3", "dec_en after mute entry",  32'(dec_en),  32'd0);
      stream(6);
      play_req = 1'b1; mute_req = 1'b0; step(NS + 1); stream(6);
      step(3);
      finish_run();
   end
endmodule